// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block converts a 32-bit virtual address into a physical address. It walks a two-level translation structure that sits in main memory. A request carries the virtual address and the base of the top-level directory. The walker then makes two dependent word reads over a simple valid/ready read port. The first read fetches a directory entry, which names the base of a second-level table. The second read fetches a table entry, which names the physical page frame. The 12-bit page offset passes through unchanged and is joined to that frame.

The upper ten bits of the virtual address select one of 1024 directory slots. The next ten bits select one of 1024 slots in the chosen table. Every entry is a 32-bit word. Bit 0 of an entry is its present flag, and bits 31..12 of an entry give a 4 KiB-aligned base. A clear present flag ends the walk with a fault. If the directory entry is absent, the second read is skipped. The walker handles one walk at a time and reports completion with a single-cycle pulse.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A `req_valid` seen while it is low has no effect on the reads issued or on the result.
- R2: In the cycle after a request is accepted, `mem_rd_valid` is high with `mem_rd_addr` = {dir_base[31:12], vaddr[31:22], 2'b00}.
- R3: While `mem_rd_valid` is high and `mem_rd_ready` is low, `mem_rd_valid` stays high and `mem_rd_addr` keeps its value, for any number of wait cycles. A read completes in a cycle where both are high, and `mem_rd_data` is taken in that cycle.
- R4: If bit 0 of the directory entry is 0, no second read is issued. In the cycle after the first read completes, `done` and `fault` are both high.
- R5: If bit 0 of the directory entry is 1, the second read is requested in the cycle after the first read completes, with `mem_rd_addr` = {pde[31:12], vaddr[21:12], 2'b00}.
- R6: If bit 0 of the table entry is 0, then in the cycle after the second read completes `done` and `fault` are high and `paddr` is 0.
- R7: If bit 0 of the table entry is 1, then in the cycle after the second read completes `done` is high, `fault` is low and `paddr` = {pte[31:12], vaddr[11:0]}.
- R8: `done` is high for exactly one cycle per walk. `req_ready` is high again in the next cycle, and `fault` is never high without `done`.
- R9: While `rst_n` is low, and right after it rises, the walker is idle. In that state `req_ready` is 1 and `mem_rd_valid`, `done` and `fault` are 0. This holds also when reset cuts into a walk.
- R10: Bits 11..1 of either entry have no effect on any address the walker produces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_dir_base | input | 32 | Directory base; bits 31..12 are used |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| mem_rd_valid | output | 1 | Memory word read request |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_ready | input | 1 | Memory completes the read this cycle |
| mem_rd_data | input | 32 | Entry word, valid while mem_rd_ready is high |
| done | output | 1 | One-cycle walk completion pulse |
| fault | output | 1 | Walk hit an absent entry (with done) |
| paddr | output | 32 | Translated physical address (with done) |

## Verification
The first read is due one cycle after the accepting edge. The bench checks its request and address at the next falling edge, and then at every falling edge of each inserted wait cycle. Every later event is due exactly one cycle after the read-completing edge that causes it: the second read, the fault after an absent directory entry, and the final result. `req_ready` is due one cycle after the `done` pulse. The bench steps through these cycles one falling edge at a time instead of polling, so a result that comes early or late fails at the exact cycle. The bench keeps its own copies of the virtual address and entry words, and it computes all expected addresses from those copies.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIR  = 2'd1,
    ST_TBL  = 2'd2,
    ST_DONE = 2'd3
  } walk_state_e;

  localparam int unsigned PRESENT_BIT = 0;
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        mem_rd_ready,
  input  logic        entry_present,
  output walk_state_e state,
  output logic        accept,
  output logic        dir_hit,
  output logic        tbl_hit
);
  walk_state_e state_nxt;

  assign accept  = (state == ST_IDLE) && req_valid;
  assign dir_hit = (state == ST_DIR) && mem_rd_ready;
  assign tbl_hit = (state == ST_TBL) && mem_rd_ready;

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE: if (req_valid)    state_nxt = ST_DIR;
      ST_DIR:  if (mem_rd_ready) state_nxt = entry_present ? ST_TBL : ST_DONE;
      ST_TBL:  if (mem_rd_ready) state_nxt = ST_DONE;
      ST_DONE:                   state_nxt = ST_IDLE;
      default:                   state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned ENT_LG = 2
) (
  input  walk_state_e       state,
  input  logic [ADDR_W-1:0] va_q,
  input  logic [ADDR_W-1:0] dir_base_q,
  input  logic [ADDR_W-1:0] tbl_base_q,
  output logic [ADDR_W-1:0] entry_addr
);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'((64'd1 << OFS_W) - 64'd1);
  localparam logic [ADDR_W-1:0] IDX_MASK = ADDR_W'((64'd1 << IDX_W) - 64'd1);
  localparam int unsigned TBL_LSB = OFS_W;
  localparam int unsigned DIR_LSB = OFS_W + IDX_W;

  logic [ADDR_W-1:0] dir_idx, tbl_idx;
  logic [ADDR_W-1:0] dir_slot, tbl_slot;

  assign dir_idx  = (va_q >> DIR_LSB) & IDX_MASK;
  assign tbl_idx  = (va_q >> TBL_LSB) & IDX_MASK;
  assign dir_slot = (dir_base_q & ~OFS_MASK) | (dir_idx << ENT_LG);
  assign tbl_slot = (tbl_base_q & ~OFS_MASK) | (tbl_idx << ENT_LG);

  always_comb begin
    entry_addr = dir_slot;
    if (state == ST_TBL) entry_addr = tbl_slot;
  end
endmodule

// File: rtl/ptw_capture.sv
module ptw_capture #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              dir_hit,
  input  logic              tbl_hit,
  input  logic              entry_present,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [ADDR_W-1:0] req_dir_base,
  input  logic [ADDR_W-1:0] mem_rd_data,
  output logic [ADDR_W-1:0] va_q,
  output logic [ADDR_W-1:0] dir_base_q,
  output logic [ADDR_W-1:0] tbl_base_q,
  output logic [ADDR_W-1:0] paddr_q,
  output logic              fault_q
);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'((64'd1 << OFS_W) - 64'd1);

  logic              fin_en;
  logic [ADDR_W-1:0] frame_addr;
  logic [ADDR_W-1:0] paddr_nxt;

  assign fin_en     = (dir_hit && !entry_present) || tbl_hit;
  assign frame_addr = (mem_rd_data & ~OFS_MASK) | (va_q & OFS_MASK);
  assign paddr_nxt  = entry_present && tbl_hit ? frame_addr : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q       <= '0;
      dir_base_q <= '0;
    end else if (accept) begin
      va_q       <= req_vaddr;
      dir_base_q <= req_dir_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tbl_base_q <= '0;
    else if (dir_hit) tbl_base_q <= mem_rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_q <= '0;
      fault_q <= 1'b0;
    end else if (fin_en) begin
      paddr_q <= paddr_nxt;
      fault_q <= !entry_present;
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [ADDR_W-1:0] req_dir_base,
  output logic              req_ready,
  output logic              mem_rd_valid,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ready,
  input  logic [ADDR_W-1:0] mem_rd_data,
  output logic              done,
  output logic              fault,
  output logic [ADDR_W-1:0] paddr
);
  localparam int unsigned ENT_LG = OFS_W - IDX_W;

  walk_state_e       state;
  logic              accept, dir_hit, tbl_hit, entry_present, fault_q;
  logic [ADDR_W-1:0] va_q, dir_base_q, tbl_base_q, paddr_q;

  assign entry_present = mem_rd_data[PRESENT_BIT];

  ptw_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .mem_rd_ready  (mem_rd_ready),
    .entry_present (entry_present),
    .state         (state),
    .accept        (accept),
    .dir_hit       (dir_hit),
    .tbl_hit       (tbl_hit)
  );

  ptw_capture #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_cap (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept        (accept),
    .dir_hit       (dir_hit),
    .tbl_hit       (tbl_hit),
    .entry_present (entry_present),
    .req_vaddr     (req_vaddr),
    .req_dir_base  (req_dir_base),
    .mem_rd_data   (mem_rd_data),
    .va_q          (va_q),
    .dir_base_q    (dir_base_q),
    .tbl_base_q    (tbl_base_q),
    .paddr_q       (paddr_q),
    .fault_q       (fault_q)
  );

  ptw_addr_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .ENT_LG(ENT_LG)) u_addr (
    .state      (state),
    .va_q       (va_q),
    .dir_base_q (dir_base_q),
    .tbl_base_q (tbl_base_q),
    .entry_addr (mem_rd_addr)
  );

  assign req_ready    = (state == ST_IDLE);
  assign mem_rd_valid = (state == ST_DIR) || (state == ST_TBL);
  assign done         = (state == ST_DONE);
  assign fault        = done && fault_q;
  assign paddr        = paddr_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic              req_ready,
  input logic              mem_rd_valid,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rd_ready,
  input logic              done,
  input logic              fault,
  input logic [ADDR_W-1:0] paddr
);
  logic [OFS_W-1:0] ofs_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ofs_seen <= '0;
    else if (req_valid && req_ready) ofs_seen <= req_vaddr[OFS_W-1:0];
  end

  a_r3_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  a_r1_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_valid);

  a_r2_read_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> mem_rd_valid);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  a_r8_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);

  a_r6_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> paddr == '0);

  a_r7_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault |-> paddr[OFS_W-1:0] == ofs_seen);

  a_r4_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_rd_valid && mem_rd_ready));
endmodule

bind ptw_walker ptw_walker_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_vaddr    (req_vaddr),
  .req_ready    (req_ready),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_addr  (mem_rd_addr),
  .mem_rd_ready (mem_rd_ready),
  .done         (done),
  .fault        (fault),
  .paddr        (paddr)
);

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_dir_base = '0;
  logic        req_ready;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        done, fault;
  logic [31:0] paddr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ptw_walker uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_dir_base(req_dir_base),
    .req_ready(req_ready),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
    .done(done), .fault(fault), .paddr(paddr)
  );

  function automatic logic [31:0] exp_dir_addr(logic [31:0] base, logic [31:0] va);
    return {base[31:12], va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] exp_tbl_addr(logic [31:0] pde, logic [31:0] va);
    return {pde[31:12], va[21:12], 2'b00};
  endfunction

  function automatic logic [31:0] exp_phys(logic [31:0] pte, logic [31:0] va);
    return {pte[31:12], va[11:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Serve one read: hold for 'waits' cycles (R3), then complete with 'data'.
  task automatic serve(input logic [31:0] addr, input int waits, input logic [31:0] data,
                       input bit poke_busy);
    for (int w = 0; w < waits; w++) begin
      if (poke_busy) begin
        req_valid = 1'b1;
        req_vaddr = ~req_vaddr;
        req_dir_base = ~req_dir_base;
      end
      @(negedge clk);
      check(mem_rd_valid === 1'b1 && mem_rd_addr === addr, "R3 held read", mem_rd_addr, addr);
      check(req_ready === 1'b0, "R1 busy not ready", {31'd0, req_ready}, 32'd0);
    end
    req_valid = 1'b0;
    mem_rd_ready = 1'b1;
    mem_rd_data = data;
    @(negedge clk);
    mem_rd_ready = 1'b0;
    mem_rd_data = $urandom;
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input logic [31:0] pde,
                      input logic [31:0] pte, input int w1, input int w2, input bit poke);
    logic [31:0] a1, a2;
    a1 = exp_dir_addr(base, va);
    a2 = exp_tbl_addr(pde, va);
    check(req_ready === 1'b1, "R8 ready before walk", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1;
    req_vaddr = va;
    req_dir_base = base;
    @(negedge clk);
    req_valid = 1'b0;
    check(mem_rd_valid === 1'b1 && mem_rd_addr === a1, "R2 directory read", mem_rd_addr, a1);
    serve(a1, w1, pde, poke);
    if (!pde[0]) begin
      check(mem_rd_valid === 1'b0, "R4 no second read", {31'd0, mem_rd_valid}, 32'd0);
      check(done === 1'b1 && fault === 1'b1, "R4 directory fault", {30'd0, done, fault}, 32'd3);
    end else begin
      check(mem_rd_valid === 1'b1 && mem_rd_addr === a2, "R5 table read", mem_rd_addr, a2);
      serve(a2, w2, pte, poke);
      if (!pte[0]) begin
        check(done === 1'b1 && fault === 1'b1, "R6 table fault", {30'd0, done, fault}, 32'd3);
        check(paddr === 32'd0, "R6 no address", paddr, 32'd0);
      end else begin
        check(done === 1'b1 && fault === 1'b0, "R7 success flags", {30'd0, done, fault}, 32'd2);
        check(paddr === exp_phys(pte, va), "R7 physical address", paddr, exp_phys(pte, va));
      end
    end
    @(negedge clk);
    check(done === 1'b0 && fault === 1'b0 && req_ready === 1'b1, "R8 single pulse",
          {29'd0, done, fault, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1 && mem_rd_valid === 1'b0 && done === 1'b0 && fault === 1'b0,
          "R9 reset state", {28'd0, req_ready, mem_rd_valid, done, fault}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1 && done === 1'b0, "R9 after release", {30'd0, req_ready, done}, 32'h2);

    // Directed corners
    walk(32'h1234_5678, 32'h0040_0000, 32'h0008_9001, 32'hABCD_E001, 0, 0, 0);
    walk(32'hFFFF_FFFF, 32'hFFFF_F000, 32'h7777_7001, 32'h0000_1001, 3, 5, 1);
    walk(32'h0000_0000, 32'h0000_0000, 32'h0010_0000, 32'h0, 2, 0, 1);   // R4 absent dir
    walk(32'h8040_1ABC, 32'h1000_0000, 32'h2000_0001, 32'h3000_0FFE, 0, 4, 0); // R6
    // R10: junk in bits 11..1 of both entries must not reach any address
    walk(32'hC030_2123, 32'h5000_0FFF, 32'h6000_1FFF, 32'h9ABC_DFFF, 1, 1, 0);

    // Mid-walk reset (R9)
    req_valid = 1'b1; req_vaddr = 32'hDEAD_BEEF; req_dir_base = 32'h0;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check(req_ready === 1'b1 && mem_rd_valid === 1'b0 && done === 1'b0 && fault === 1'b0,
          "R9 reset in walk", {28'd0, req_ready, mem_rd_valid, done, fault}, 32'h8);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Constrained random walks
    for (int n = 0; n < 400; n++) begin
      logic [31:0] pde, pte;
      pde = $urandom;
      pte = $urandom;
      pde[0] = ($urandom % 5) != 0;
      pte[0] = ($urandom % 5) != 0;
      walk($urandom, $urandom, pde, pte, $urandom % 4, $urandom % 4, $urandom % 2);
    end

    finish_run();
  end
endmodule